// File: doc/BRIEF.md
# Thermal Sensor Register Bank

This block is the register file and alarm engine of a board-level temperature sensor of the kind fitted to memory modules. An external converter hands it a signed 13-bit temperature sample with a one-cycle strobe. The block stores the latest sample and compares it against three programmable thresholds: an upper limit, a lower limit and a critical limit. Each comparison drives its own sticky status bit. Every status bit releases only after the temperature has moved back across its threshold by a programmable hysteresis margin.

A host reaches the registers through a flat parallel port with address, write data, write strobe and read strobe. Read data is a registered 16-bit word. Bits 15:8 are the byte a serial bridge sends first, so the word can be shifted out most significant byte first without rearranging. Lock bits in the configuration register can freeze the thresholds and the hysteresis choice until reset. A shutdown bit freezes sampling. One event pin summarises the alarms, either all three of them or the critical one alone.

Top module: `tsense_regbank`

## Requirements
- R1: After reset, every writable register and every alarm bit reads as zero, the temperature field reads zero, and `event_o` is low.
- R2: Reads are decoded as follows. Address 0x00 returns `{8'h00, CAP_LOW}`, with the extended-range flag in bit 2. Address 0x06 returns `MAN_ID` and 0x07 returns `DEV_ID`. Any address other than 0x00–0x07 and 0x22 returns 0x0000.
- R3: Writes take effect only at addresses 0x01–0x04 and 0x22. A write to any other address, including the temperature register 0x05, leaves every register unchanged.
- R4: The threshold registers (upper 0x02, lower 0x03, critical 0x04) hold 13-bit two's-complement values with an LSB of 0.0625 °C. A write keeps bits 12:0, and bits 15:13 read as zero.
- R5: While the block is not shut down, a sample strobe loads the 13-bit sample into bits 12:0 of the temperature register 0x05. Bit 15 of that register is the critical alarm, bit 14 the upper alarm and bit 13 the lower alarm. Register state is visible to a read strobe issued from the next cycle on.
- R6: The upper alarm sets when a sample is strictly greater than the upper limit. It clears when a sample is at or below the upper limit minus the hysteresis, and otherwise holds.
- R7: The lower alarm sets when a sample is strictly less than the lower limit. It clears when a sample is at or above the lower limit plus the hysteresis, and otherwise holds.
- R8: The critical alarm sets when a sample is at or above the critical limit. It clears when a sample is strictly below the critical limit minus the hysteresis, and otherwise holds.
- R9: Configuration register 0x01 stores the hysteresis code in bits 10:9, where codes 0/1/2/3 give 0/24/48/96 LSB. It also stores shutdown in bit 8, the threshold lock in bit 7, the critical lock in bit 6 and critical-only mode in bit 2. All other configuration bits read as zero.
- R10: Once written to one, the threshold lock (bit 7) and the critical lock (bit 6) stay set until reset. Bit 7 makes writes to 0x02 and 0x03 have no effect, and bit 6 does the same for 0x04. While either lock is set, the hysteresis code cannot change.
- R11: While shutdown (bit 8) is set, sample strobes change neither the temperature field nor any alarm bit. After shutdown is cleared, the next strobe is processed normally.
- R12: `event_o` is the OR of the three alarm bits. When critical-only mode (bit 2) is set, it follows the critical alarm alone.
- R13: Register 0x22 stores only bit 7, the active-low bus-timeout control. All of its other bits read as zero.
- R14: `rdata` is loaded on the clock edge where `rd_en` is high and holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new converter sample |
| smp_temp | input | 13 | Signed sample, 0.0625 °C per LSB |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Registered read word, bits 15:8 are sent first |
| event_o | output | 1 | Alarm summary pin |

## Verification
The temperature is walked through each threshold from both sides, and the approach is repeated with a zero and a non-zero hysteresis margin. A sample that lands between the threshold and the release point must then keep the previous alarm state; this separates a correct hysteresis band from one that is applied on the wrong side or not at all. Negative samples check the sign handling of the comparators. Samples exactly on a limit distinguish the strict comparison of the upper and lower alarms from the inclusive comparison of the critical alarm. Writes are aimed at read-only addresses, at locked thresholds and at a frozen hysteresis field, and each one is read back. A mid-band sample with only the upper alarm active tells critical-only mode apart from the normal OR on the event pin.

// File: rtl/tsense_pkg.sv
`timescale 1ns/1ps
package tsense_pkg;

    localparam int TEMP_W = 13;
    localparam int CMP_W  = TEMP_W + 2;

    localparam logic [7:0] A_CAP   = 8'h00;
    localparam logic [7:0] A_CFG   = 8'h01;
    localparam logic [7:0] A_UPPER = 8'h02;
    localparam logic [7:0] A_LOWER = 8'h03;
    localparam logic [7:0] A_CRIT  = 8'h04;
    localparam logic [7:0] A_TEMP  = 8'h05;
    localparam logic [7:0] A_MANID = 8'h06;
    localparam logic [7:0] A_DEVID = 8'h07;
    localparam logic [7:0] A_BUS   = 8'h22;

    typedef struct packed {
        logic [1:0] hyst;
        logic       shdn;
        logic       ev_lock;
        logic       cr_lock;
        logic       crit_only;
    } cfg_t;

    // hysteresis code to margin in sample LSBs
    function automatic logic signed [CMP_W-1:0] hyst_lsb(input logic [1:0] code);
        case (code)
            2'd0:    return CMP_W'(0);
            2'd1:    return CMP_W'(24);
            2'd2:    return CMP_W'(48);
            default: return CMP_W'(96);
        endcase
    endfunction

    function automatic logic signed [CMP_W-1:0] widen(input logic [TEMP_W-1:0] v);
        return {{(CMP_W-TEMP_W){v[TEMP_W-1]}}, v};
    endfunction

endpackage

// File: rtl/tsense_ctrl.sv
`timescale 1ns/1ps
module tsense_ctrl
    import tsense_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    output cfg_t              cfg,
    output logic [TEMP_W-1:0] upper_lim,
    output logic [TEMP_W-1:0] lower_lim,
    output logic [TEMP_W-1:0] crit_lim,
    output logic              bus_to
);

    typedef struct packed {
        cfg_t              cfg;
        logic [TEMP_W-1:0] upper;
        logic [TEMP_W-1:0] lower;
        logic [TEMP_W-1:0] crit;
        logic              bus_to;
    } ctrl_t;

    ctrl_t st_d, st_q;

    wire unused_wdata = ^{wdata[DW-1:11], wdata[5:3], wdata[1:0]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                A_CFG: begin
                    st_d.cfg.shdn      = wdata[8];
                    st_d.cfg.crit_only = wdata[2];
                    st_d.cfg.ev_lock   = st_q.cfg.ev_lock | wdata[7];
                    st_d.cfg.cr_lock   = st_q.cfg.cr_lock | wdata[6];
                    if (!st_q.cfg.ev_lock && !st_q.cfg.cr_lock)
                        st_d.cfg.hyst = wdata[10:9];
                end
                A_UPPER: if (!st_q.cfg.ev_lock) st_d.upper = wdata[TEMP_W-1:0];
                A_LOWER: if (!st_q.cfg.ev_lock) st_d.lower = wdata[TEMP_W-1:0];
                A_CRIT:  if (!st_q.cfg.cr_lock) st_d.crit  = wdata[TEMP_W-1:0];
                A_BUS:   st_d.bus_to = wdata[7];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg       = st_q.cfg;
    assign upper_lim = st_q.upper;
    assign lower_lim = st_q.lower;
    assign crit_lim  = st_q.crit;
    assign bus_to    = st_q.bus_to;

endmodule

// File: rtl/tsense_alarm.sv
`timescale 1ns/1ps
module tsense_alarm
    import tsense_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_temp,
    input  cfg_t              cfg,
    input  logic [TEMP_W-1:0] upper_lim,
    input  logic [TEMP_W-1:0] lower_lim,
    input  logic [TEMP_W-1:0] crit_lim,
    output logic [TEMP_W-1:0] temp,
    output logic              al_crit,
    output logic              al_up,
    output logic              al_lo,
    output logic              event_o
);

    typedef struct packed {
        logic [TEMP_W-1:0] temp;
        logic              crit;
        logic              up;
        logic              lo;
    } alarm_t;

    alarm_t st_d, st_q;

    logic signed [CMP_W-1:0] t_s, up_s, lo_s, cr_s, h_s;

    always_comb begin
        t_s  = widen(smp_temp);
        up_s = widen(upper_lim);
        lo_s = widen(lower_lim);
        cr_s = widen(crit_lim);
        h_s  = hyst_lsb(cfg.hyst);

        st_d = st_q;
        if (smp_valid && !cfg.shdn) begin
            st_d.temp = smp_temp;

            if (t_s > up_s)             st_d.up = 1'b1;
            else if (t_s <= up_s - h_s) st_d.up = 1'b0;

            if (t_s < lo_s)             st_d.lo = 1'b1;
            else if (t_s >= lo_s + h_s) st_d.lo = 1'b0;

            if (t_s >= cr_s)            st_d.crit = 1'b1;
            else if (t_s < cr_s - h_s)  st_d.crit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign temp    = st_q.temp;
    assign al_crit = st_q.crit;
    assign al_up   = st_q.up;
    assign al_lo   = st_q.lo;
    assign event_o = cfg.crit_only ? st_q.crit : (st_q.crit | st_q.up | st_q.lo);

endmodule

// File: rtl/tsense_rdmux.sv
`timescale 1ns/1ps
module tsense_rdmux
    import tsense_pkg::*;
#(
    parameter int          AW      = 8,
    parameter int          DW      = 16,
    parameter logic [7:0]  CAP_LOW = 8'h05,
    parameter logic [15:0] MAN_ID  = 16'h1B2C,
    parameter logic [15:0] DEV_ID  = 16'h3A01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              rd_en,
    input  cfg_t              cfg,
    input  logic [TEMP_W-1:0] upper_lim,
    input  logic [TEMP_W-1:0] lower_lim,
    input  logic [TEMP_W-1:0] crit_lim,
    input  logic              bus_to,
    input  logic [TEMP_W-1:0] temp,
    input  logic              al_crit,
    input  logic              al_up,
    input  logic              al_lo,
    output logic [DW-1:0]     rdata
);

    localparam int PAD = DW - TEMP_W;

    logic [DW-1:0] rd_d, rd_q, word;

    always_comb begin
        case (addr)
            A_CAP:   word = DW'({8'h00, CAP_LOW});
            A_CFG:   word = DW'({5'b0, cfg.hyst, cfg.shdn, cfg.ev_lock, cfg.cr_lock,
                                 3'b0, cfg.crit_only, 2'b0});
            A_UPPER: word = {{PAD{1'b0}}, upper_lim};
            A_LOWER: word = {{PAD{1'b0}}, lower_lim};
            A_CRIT:  word = {{PAD{1'b0}}, crit_lim};
            A_TEMP:  word = {al_crit, al_up, al_lo, temp};
            A_MANID: word = DW'(MAN_ID);
            A_DEVID: word = DW'(DEV_ID);
            A_BUS:   word = DW'({8'h00, bus_to, 7'b0});
            default: word = '0;
        endcase
        rd_d = rd_en ? word : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;

endmodule

// File: rtl/tsense_regbank.sv
`timescale 1ns/1ps
module tsense_regbank
    import tsense_pkg::*;
#(
    parameter logic [7:0]  CAP_LOW = 8'h05,
    parameter logic [15:0] MAN_ID  = 16'h1B2C,
    parameter logic [15:0] DEV_ID  = 16'h3A01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [12:0]   smp_temp,
    input  logic [7:0]    addr,
    input  logic [15:0]   wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [15:0]   rdata,
    output logic          event_o
);

    cfg_t              cfg_q;
    logic [TEMP_W-1:0] upper_lim, lower_lim, crit_lim, temp_q;
    logic              bus_to, al_crit, al_up, al_lo;

    tsense_ctrl #(.AW(8), .DW(16)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .cfg       (cfg_q),
        .upper_lim (upper_lim),
        .lower_lim (lower_lim),
        .crit_lim  (crit_lim),
        .bus_to    (bus_to)
    );

    tsense_alarm u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_temp  (smp_temp),
        .cfg       (cfg_q),
        .upper_lim (upper_lim),
        .lower_lim (lower_lim),
        .crit_lim  (crit_lim),
        .temp      (temp_q),
        .al_crit   (al_crit),
        .al_up     (al_up),
        .al_lo     (al_lo),
        .event_o   (event_o)
    );

    tsense_rdmux #(
        .AW(8), .DW(16), .CAP_LOW(CAP_LOW), .MAN_ID(MAN_ID), .DEV_ID(DEV_ID)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .rd_en     (rd_en),
        .cfg       (cfg_q),
        .upper_lim (upper_lim),
        .lower_lim (lower_lim),
        .crit_lim  (crit_lim),
        .bus_to    (bus_to),
        .temp      (temp_q),
        .al_crit   (al_crit),
        .al_up     (al_up),
        .al_lo     (al_lo),
        .rdata     (rdata)
    );

endmodule

// File: rtl/tsense_chk.sv
`timescale 1ns/1ps
module tsense_chk
    import tsense_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [TEMP_W-1:0] smp_temp,
    input logic [7:0]        addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [15:0]       rdata,
    input logic              event_o,
    input cfg_t              cfg_q,
    input logic [TEMP_W-1:0] upper_lim,
    input logic [TEMP_W-1:0] crit_lim,
    input logic [TEMP_W-1:0] temp_q,
    input logic              al_crit
);

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ev_lock || cfg_q.cr_lock) |=>
            ((cfg_q.ev_lock || !$past(cfg_q.ev_lock)) && (cfg_q.cr_lock || !$past(cfg_q.cr_lock))));

    // R10
    upper_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ev_lock && wr_en && addr == A_UPPER) |=> $stable(upper_lim));

    // R11
    shdn_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.shdn |=> $stable(temp_q));

    // R8
    crit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cfg_q.shdn && ($signed(smp_temp) >= $signed(crit_lim))) |=> al_crit);

    // R12
    crit_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        al_crit |-> event_o);

    // R14
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind tsense_regbank tsense_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_temp  (smp_temp),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .event_o   (event_o),
    .cfg_q     (cfg_q),
    .upper_lim (upper_lim),
    .crit_lim  (crit_lim),
    .temp_q    (temp_q),
    .al_crit   (al_crit)
);

// File: tb/sim_tsense_regbank.sv
`timescale 1ns/1ps
module sim_tsense_regbank;

    localparam logic [7:0]  CAP = 8'h05;
    localparam logic [15:0] MID = 16'h1B2C;
    localparam logic [15:0] DID = 16'h3A01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [12:0] smp_temp = '0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        event_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    tsense_regbank #(.CAP_LOW(CAP), .MAN_ID(MID), .DEV_ID(DID)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .rdata(rdata), .event_o(event_o)
    );

    // temperature register word: crit bit15, upper bit14, lower bit13, sample 12:0
    function automatic logic [15:0] tword(bit c, bit u, bit l, int t);
        logic [12:0] f = 13'(t);
        return {c, u, l, f};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic smp(input int t);
        @(negedge clk); smp_temp = 13'(t); smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic chk_evt(input bit e, input string tag);
        @(negedge clk);
        checks++;
        if (event_o !== e) begin
            errors++;
            $display("FAIL %s: event_o actual=%0b expected=%0b", tag, event_o, e);
        end
    endtask

    // monitor: compare every read word one edge after its strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                checks++;
                if (rdata !== exp_q[0]) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%h expected=%h", tag_q[0], rdata, exp_q[0]);
                end
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_evt(1'b0, "R1 event after reset");
        rd(8'h01, 16'h0000, "R1 config reset");
        rd(8'h05, 16'h0000, "R1 temperature reset");
        rd(8'h02, 16'h0000, "R1 upper reset");
        rd(8'h22, 16'h0000, "R1 bus reg reset");
        // R2 identification and unmapped space
        rd(8'h00, {8'h00, CAP}, "R2 capability");
        rd(8'h06, MID, "R2 manufacturer id");
        rd(8'h07, DID, "R2 device id");
        rd(8'h10, 16'h0000, "R2 unmapped address");

        // R4 limits keep bits 12:0
        wr(8'h02, 16'hE500);
        wr(8'h03, 16'h0140);
        wr(8'h04, 16'h05A0);
        rd(8'h02, 16'h0500, "R4 upper masked");
        rd(8'h03, 16'h0140, "R4 lower");
        rd(8'h04, 16'h05A0, "R4 critical");

        // R3 writes to read-only addresses
        wr(8'h05, 16'hFFFF);
        wr(8'h00, 16'hFFFF);
        wr(8'h06, 16'h0000);
        wr(8'h33, 16'hFFFF);
        rd(8'h05, 16'h0000, "R3 temperature not writable");
        rd(8'h00, {8'h00, CAP}, "R3 capability not writable");
        rd(8'h06, MID, "R3 id not writable");

        // R5 sample load, no alarm
        smp(400);
        rd(8'h05, tword(0, 0, 0, 400), "R5 sample 25C");
        chk_evt(1'b0, "R12 no alarm");

        // R7 lower alarm, hysteresis 0, negative sample
        smp(160);
        rd(8'h05, tword(0, 0, 1, 160), "R7 below lower");
        chk_evt(1'b1, "R12 lower drives event");
        smp(-80);
        rd(8'h05, tword(0, 0, 1, -80), "R5 negative sample");
        smp(320);
        rd(8'h05, tword(0, 0, 0, 320), "R9 zero hysteresis release at limit");

        // R9 hysteresis 48 LSB
        wr(8'h01, 16'h0400);
        rd(8'h01, 16'h0400, "R9 config hysteresis code");
        smp(100);
        smp(330);
        rd(8'h05, tword(0, 0, 1, 330), "R7 held inside band");
        smp(367);
        rd(8'h05, tword(0, 0, 1, 367), "R7 held one below release");
        smp(368);
        rd(8'h05, tword(0, 0, 0, 368), "R7 released at lower+hyst");

        // R6 upper alarm
        smp(1280);
        rd(8'h05, tword(0, 0, 0, 1280), "R6 equal to upper no alarm");
        smp(1281);
        rd(8'h05, tword(0, 1, 0, 1281), "R6 above upper");
        smp(1250);
        rd(8'h05, tword(0, 1, 0, 1250), "R6 held inside band");
        smp(1232);
        rd(8'h05, tword(0, 0, 0, 1232), "R6 released at upper-hyst");

        // R8 critical alarm
        smp(1440);
        rd(8'h05, tword(1, 1, 0, 1440), "R8 equal to critical sets");
        smp(1400);
        rd(8'h05, tword(1, 1, 0, 1400), "R8 held inside band");

        // R12 critical-only
        wr(8'h01, 16'h0404);
        chk_evt(1'b1, "R12 critical-only with critical");
        smp(1300);
        rd(8'h05, tword(0, 1, 0, 1300), "R8 released below crit-hyst");
        chk_evt(1'b0, "R12 critical-only masks upper");
        wr(8'h01, 16'h0400);
        chk_evt(1'b1, "R12 upper drives event");

        // R11 shutdown freeze
        wr(8'h01, 16'h0500);
        rd(8'h01, 16'h0500, "R9 shutdown bit stored");
        smp(100);
        rd(8'h05, tword(0, 1, 0, 1300), "R11 frozen during shutdown");
        wr(8'h01, 16'h0400);
        smp(100);
        rd(8'h05, tword(0, 0, 1, 100), "R11 resumed after shutdown");

        // R13 bus-control register
        wr(8'h22, 16'hFFFF);
        rd(8'h22, 16'h0080, "R13 only bit7 stored");

        // R10 locks
        wr(8'h01, 16'h0480);
        rd(8'h01, 16'h0480, "R10 threshold lock set");
        wr(8'h02, 16'h0100);
        rd(8'h02, 16'h0500, "R10 upper locked");
        wr(8'h03, 16'h0000);
        rd(8'h03, 16'h0140, "R10 lower locked");
        wr(8'h04, 16'h0100);
        rd(8'h04, 16'h0100, "R10 critical still writable");
        wr(8'h04, 16'h05A0);
        wr(8'h01, 16'h0000);
        rd(8'h01, 16'h0480, "R10 lock sticky and hysteresis frozen");
        wr(8'h01, 16'h06C0);
        rd(8'h01, 16'h04C0, "R10 critical lock set hysteresis unchanged");
        wr(8'h04, 16'h0000);
        rd(8'h04, 16'h05A0, "R10 critical locked");

        // R14 rdata holds without a read strobe
        wr(8'h22, 16'h0000);
        @(negedge clk); addr = 8'h07;
        @(negedge clk);
        checks++;
        if (rdata !== 16'h05A0) begin
            errors++;
            $display("FAIL R14 rdata hold: actual=%h expected=%h", rdata, 16'h05A0);
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule